// File: doc/BRIEF.md
# E1 National Bit Codeword Debouncer

This block collects the five national bits (Sa4 to Sa8) that an E1 receiver finds in the four non-alignment frames of each CRC sub-multiframe. For each national bit position it builds a 4-bit codeword. The codewords go into five holding registers. Each register has a sticky change flag, raised when a write alters its contents.

An optional debounce mode filters the updates. When it is on, a register accepts a codeword only if the same codeword also arrived in the sub-multiframe just before. While CRC multiframe sync is lost, all holding registers keep their values. Losing sync also discards the debounce history, so after sync returns two fresh matching sub-multiframes are needed before a debounced write can happen.

Software clears a change flag by writing one to its bit.

Top module: `e1_sa_codeword_debounce`

## Requirements
- R1: `sa_bits[k]` carries Sa(4+k) and is sampled on each `nfas_vld` strobe. The bit sampled first in a sub-multiframe becomes codeword bit 3 (the MSB). Codeword Sa(4+k) appears on `codeword_o[4k+3:4k]`.
- R2: With `deb_en` low, every `smf_end` strobe taken while `mf_sync` is high writes all five registers with the codewords from the last four strobes.
- R3: With `deb_en` high, a register is written only when the new codeword equals the codeword received at the previous in-sync `smf_end`.
- R4: In either mode, `chg_flag_o[k]` is set when a write changes register k. A write of an equal value leaves the flag untouched.
- R5: While `mf_sync` is low, `smf_end` strobes are ignored and all registers hold their value.
- R6: After sync is regained with debounce on, the first in-sync sub-multiframe cannot write. The second one writes if it matches the first.
- R7: Change flags stay set until a one is written to `flag_clr[k]`. If a new change and a clear arrive in the same cycle, the flag stays set.
- R8: After reset, all codewords and all change flags are zero.
- R9: Registers change only on the clock edge that takes an in-sync `smf_end`. Strobes on `nfas_vld` alone do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nfas_vld | input | 1 | One-cycle strobe: national bits of a non-alignment frame valid |
| sa_bits | input | 5 | Sa4..Sa8 bits, bit k = Sa(4+k) |
| smf_end | input | 1 | One-cycle strobe at the end of a CRC sub-multiframe |
| mf_sync | input | 1 | CRC multiframe sync is held |
| deb_en | input | 1 | Debounce enable |
| flag_clr | input | 5 | Write-one-to-clear for the change flags |
| codeword_o | output | 20 | Five stored codewords, 4 bits each, Sa4 in the low nibble |
| chg_flag_o | output | 5 | Sticky change flags, bit k for Sa(4+k) |

## Verification
The assertions assume that `smf_end` never arrives in the same cycle as `nfas_vld`. They also assume exactly four `nfas_vld` strobes between two `smf_end` strobes, so that each codeword is made of bits from a single sub-multiframe. The bench drives every sub-multiframe as four separate one-cycle frame strobes followed by a lone end strobe. It changes `mf_sync` and `deb_en` only between sub-multiframes. It asserts `flag_clr` either on its own or exactly together with an end strobe, to exercise the collision case.

// File: rtl/e1_sa_codeword_debounce.sv
module e1_sa_codeword_debounce #(
  parameter int NSA = 5,
  parameter int CW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nfas_vld,
  input  logic [NSA-1:0]    sa_bits,
  input  logic              smf_end,
  input  logic              mf_sync,
  input  logic              deb_en,
  input  logic [NSA-1:0]    flag_clr,
  output logic [NSA*CW-1:0] codeword_o,
  output logic [NSA-1:0]    chg_flag_o
);
  localparam int W = NSA * CW;

  logic [W-1:0]   shr, rx_now, last_rx;
  logic           last_vld, take, wr;
  logic [NSA-1:0] chg;

  for (genvar k = 0; k < NSA; k++) begin : g_lane
    assign rx_now[k*CW +: CW] = nfas_vld ? {shr[k*CW +: CW-1], sa_bits[k]} : shr[k*CW +: CW];
    assign chg[k] = wr && (rx_now[k*CW +: CW] != codeword_o[k*CW +: CW]);

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flag_o[k]) |-> codeword_o[k*CW +: CW] != $past(codeword_o[k*CW +: CW]));
    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chg_flag_o[k]) |-> $past(flag_clr[k]));
  end

  assign take = smf_end && mf_sync;
  assign wr   = take && (!deb_en || (last_vld && last_rx == rx_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shr        <= '0;
      last_rx    <= '0;
      last_vld   <= 1'b0;
      codeword_o <= '0;
      chg_flag_o <= '0;
    end else begin
      shr <= rx_now;
      if (!mf_sync) begin
        last_rx  <= '0;
        last_vld <= 1'b0;
      end else if (smf_end) begin
        last_rx  <= rx_now;
        last_vld <= 1'b1;
      end
      if (wr) codeword_o <= rx_now;
      chg_flag_o <= (chg_flag_o & ~flag_clr) | chg;
    end
  end

  // R5
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_sync |=> codeword_o == $past(codeword_o));
  // R9
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smf_end |=> codeword_o == $past(codeword_o));
endmodule

// File: tb/sim_e1_sa_codeword_debounce.sv
`timescale 1ns/1ps
module sim_e1_sa_codeword_debounce;
  logic clk = 0, rst_n = 0;
  logic nfas_vld = 0, smf_end = 0, mf_sync = 1, deb_en = 0;
  logic [4:0] sa_bits = '0, flag_clr = '0;
  logic [19:0] codeword_o;
  logic [4:0] chg_flag_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [19:0] m_cw = '0, m_last = '0;
  logic [4:0]  m_flag = '0;
  bit m_lv = 0;

  always #4 clk = ~clk;

  e1_sa_codeword_debounce u0 (.clk, .rst_n, .nfas_vld, .sa_bits, .smf_end, .mf_sync,
    .deb_en, .flag_clr, .codeword_o, .chg_flag_o);

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " codeword"}, codeword_o, m_cw);
    chk({tag, " flags"}, {15'd0, chg_flag_o}, {15'd0, m_flag});
  endtask

  task automatic send_smf(input logic [19:0] v, input logic [4:0] clr);
    logic [4:0] ch;
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      nfas_vld = 1;
      for (int k = 0; k < 5; k++) sa_bits[k] = v[k*4 + 3 - f];
      @(negedge clk);
      nfas_vld = 0;
    end
    chk("R9 no write before end strobe", codeword_o, m_cw);
    smf_end = 1; flag_clr = clr;
    @(negedge clk);
    smf_end = 0; flag_clr = '0;
    ch = '0;
    if (mf_sync) begin
      if (!deb_en || (m_lv && m_last == v)) begin
        for (int k = 0; k < 5; k++) ch[k] = (v[k*4 +: 4] != m_cw[k*4 +: 4]);
        m_cw = v;
      end
      m_last = v; m_lv = 1;
    end
    m_flag = (m_flag & ~clr) | ch;
  endtask

  task automatic clear_flags(input logic [4:0] c);
    @(negedge clk); flag_clr = c;
    @(negedge clk); flag_clr = '0;
    m_flag = m_flag & ~c;
  endtask

  task automatic t_reset;
    check_all("R8 reset");
  endtask

  task automatic t_plain;
    deb_en = 0;
    send_smf(20'h12345, '0);
    check_all("R1 R2 R4 first write");
    chk("R4 all flags", {15'd0, chg_flag_o}, 20'h1F);
    send_smf(20'h12345, '0);
    check_all("R7 sticky after equal write");
    clear_flags(5'h1F);
    chk("R7 cleared", {15'd0, chg_flag_o}, 20'h0);
    send_smf(20'h12345, '0);
    chk("R4 equal write no flag", {15'd0, chg_flag_o}, 20'h0);
    send_smf(20'h12395, '0);
    chk("R4 single lane flag", {15'd0, chg_flag_o}, 20'h2);
    check_all("R2 partial change");
    send_smf(20'h8000F, '0);
    chk("R1 msb first", codeword_o, 20'h8000F);
    clear_flags(5'h1F);
  endtask

  task automatic t_debounce;
    deb_en = 1;
    send_smf(20'hABCDE, '0);
    chk("R3 single value blocked", codeword_o, 20'h8000F);
    check_all("R3 blocked");
    send_smf(20'hABCDE, '0);
    chk("R3 repeated value accepted", codeword_o, 20'hABCDE);
    check_all("R3 R4 accepted");
    send_smf(20'h11111, '0);
    send_smf(20'h22222, '0);
    chk("R3 alternating blocked", codeword_o, 20'hABCDE);
    clear_flags(5'h1F);
  endtask

  task automatic t_sync;
    @(negedge clk); mf_sync = 0; m_lv = 0;
    deb_en = 0;
    send_smf(20'h00000, '0);
    send_smf(20'h00000, '0);
    chk("R5 hold while out of sync", codeword_o, 20'hABCDE);
    check_all("R5 no flags");
    @(negedge clk); mf_sync = 1; deb_en = 1;
    send_smf(20'h55555, '0);
    chk("R6 first after resync blocked", codeword_o, 20'hABCDE);
    send_smf(20'h55555, '0);
    chk("R6 second after resync writes", codeword_o, 20'h55555);
    check_all("R6");
    clear_flags(5'h1F);
  endtask

  task automatic t_collide;
    deb_en = 0;
    send_smf(20'h55556, 5'h01);
    chk("R7 set wins over clear", {15'd0, chg_flag_o}, 20'h1);
    send_smf(20'h65556, '0);
    clear_flags(5'h01);
    chk("R7 partial clear", {15'd0, chg_flag_o}, 20'h10);
    check_all("R7");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_debounce();
    t_sync();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule